// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner with Sign Extension

This block sits in the data path of a load/store unit, between a 32-bit memory read bus and a register-file write port. On the load side it takes the raw word returned from byte-addressable memory, the low two bits of the access address, an access size, a signed/unsigned flag and an endianness select. It returns the addressed item right-justified in 32 bits, either sign-extended or zero-filled.

On the store side it takes the register value and places the addressed byte, halfword or word into the byte lanes the memory expects. It also produces a byte-enable mask. A shared checker flags any access whose size and address do not line up.

All results pass through one output stage. With `REG_OUT=1`, the default, that stage is a register with a synchronous active-high reset. With `REG_OUT=0` it is a plain wire.

Top module: `lsu_lane_unit`

## Requirements
- R1: Bus lane k (bits 8k+7..8k of `rd_word` and `st_word`) always carries the byte at address offset k. This holds in both endian modes. A byte load returns lane `addr_lo`.
- R2: `acc_size` is encoded as 00 byte, 01 halfword, 10 word and 11 reserved. `misalign` is 0 for bytes. It is 1 for halfwords when `addr_lo[0]`=1, for words when `addr_lo`≠0, and always for 11. Load data is don't-care while `misalign`=1.
- R3: With `big_end`=0, a halfword or word load places the byte at the lowest address in the least significant position.
- R4: With `big_end`=1, a halfword or word load places the byte at the lowest address in the most significant position.
- R5: With `sign_ext`=1, byte and halfword loads copy the item's top bit into all upper bits of `ld_data`.
- R6: With `sign_ext`=0, byte and halfword loads fill the upper bits of `ld_data` with zeros.
- R7: A word load ignores `sign_ext` and returns all 32 bits, ordered per R3/R4.
- R8: Store data is placed as follows. A byte store copies `st_val[7:0]` into all four lanes. A halfword store repeats the addressed halfword in both lane pairs, MSB in the lower lane when `big_end`=1 and LSB in the lower lane otherwise. A word store is `st_val` unchanged in little-endian mode and byte-reversed in big-endian mode.
- R9: `st_be` bit k is 1 exactly when lane k is covered by an aligned access: one bit for a byte, two for a halfword, all four for a word. `st_be` is 0000 when `misalign`=1.
- R10: With `REG_OUT=1`, every output reflects the inputs one clock edge after they are applied. While `rst` is high at an edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_word | input | 32 | Raw word from the memory read bus |
| addr_lo | input | 2 | Low address bits (byte offset within the word) |
| acc_size | input | 2 | Access size code |
| sign_ext | input | 1 | 1 = signed load, 0 = unsigned load |
| big_end | input | 1 | 1 = big-endian, 0 = little-endian |
| st_val | input | 32 | Register value to be stored |
| ld_data | output | 32 | Aligned, extended load result |
| misalign | output | 1 | Access size and address disagree |
| st_word | output | 32 | Store data placed in byte lanes |
| st_be | output | 4 | Store byte enables, one per lane |

## Verification
The hardest cases to reach are the rare combinations of size and address: the reserved size code, and misaligned halfword and word stores. In these cases the lane data still looks plausible, yet the byte enables must be fully suppressed.

The bench therefore sweeps every combination of size code, byte offset, endianness and sign flag against eight data patterns. The patterns set and clear the sign bits of every lane, so each extension path and each swap is exercised with both polarities. Expected values come from a byte-by-byte address model, not from lane multiplexers.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  localparam int LANE_W = 8;
endpackage

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
  import lsu_lane_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  acc_size_e        size,
  input  logic [OFS_W-1:0] ofs,
  output logic             misalign
);
  always_comb begin
    unique case (size)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = ofs[0];
      SZ_WORD: misalign = |ofs;
      default: misalign = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [OFS_W-1:0]  ofs,
  input  acc_size_e         size,
  input  logic              sign_ext,
  input  logic              big_end,
  output logic [DATA_W-1:0] data
);
  logic [LANE_W-1:0]   lane [LANES];
  logic [DATA_W-1:0]   word_rev;
  logic [LANE_W-1:0]   b_sel, h_first, h_second;
  logic [2*LANE_W-1:0] h_val;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane[k] = word[k*LANE_W +: LANE_W];
    assign word_rev[k*LANE_W +: LANE_W] = word[(LANES-1-k)*LANE_W +: LANE_W];
  end

  always_comb begin
    b_sel    = lane[ofs];
    h_first  = lane[{ofs[OFS_W-1:1], 1'b0}];
    h_second = lane[{ofs[OFS_W-1:1], 1'b1}];
    h_val    = big_end ? {h_first, h_second} : {h_second, h_first};
    unique case (size)
      SZ_BYTE: data = {{(DATA_W-LANE_W){sign_ext & b_sel[LANE_W-1]}}, b_sel};
      SZ_HALF: data = {{(DATA_W-2*LANE_W){sign_ext & h_val[2*LANE_W-1]}}, h_val};
      default: data = big_end ? word_rev : word;
    endcase
  end
endmodule

// File: rtl/lsu_store_place.sv
module lsu_store_place
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] st_val,
  input  logic [OFS_W-1:0]  ofs,
  input  acc_size_e         size,
  input  logic              big_end,
  input  logic              misalign,
  output logic [DATA_W-1:0] st_word,
  output logic [LANES-1:0]  st_be
);
  logic [2*LANE_W-1:0] half_ord;
  logic [DATA_W-1:0]   word_ord;

  assign half_ord = big_end ? {st_val[LANE_W-1:0], st_val[2*LANE_W-1:LANE_W]}
                            : st_val[2*LANE_W-1:0];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign word_ord[k*LANE_W +: LANE_W] =
      big_end ? st_val[(LANES-1-k)*LANE_W +: LANE_W] : st_val[k*LANE_W +: LANE_W];

    always_comb begin
      unique case (size)
        SZ_BYTE: st_word[k*LANE_W +: LANE_W] = st_val[LANE_W-1:0];
        SZ_HALF: st_word[k*LANE_W +: LANE_W] = half_ord[(k%2)*LANE_W +: LANE_W];
        default: st_word[k*LANE_W +: LANE_W] = word_ord[k*LANE_W +: LANE_W];
      endcase
    end

    always_comb begin
      unique case (size)
        SZ_BYTE: st_be[k] = (OFS_W'(k) == ofs);
        SZ_HALF: st_be[k] = (OFS_W'(k >> 1) == OFS_W'(ofs >> 1));
        SZ_WORD: st_be[k] = 1'b1;
        default: st_be[k] = 1'b0;
      endcase
      if (misalign) st_be[k] = 1'b0;
    end
  end
endmodule

// File: rtl/lsu_out_stage.sv
module lsu_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
    end
  end else begin : g_wire
    logic unused_ok;
    assign unused_ok = clk ^ rst;
    assign q = d;
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int LANES  = DATA_W / LANE_W,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [OFS_W-1:0]  addr_lo,
  input  logic [1:0]        acc_size,
  input  logic              sign_ext,
  input  logic              big_end,
  input  logic [DATA_W-1:0] st_val,
  output logic [DATA_W-1:0] ld_data,
  output logic              misalign,
  output logic [DATA_W-1:0] st_word,
  output logic [LANES-1:0]  st_be
);
  localparam int OUT_W = 2*DATA_W + 1 + LANES;

  acc_size_e         sz;
  logic              mis_c;
  logic [DATA_W-1:0] ld_c, st_c;
  logic [LANES-1:0]  be_c;

  assign sz = acc_size_e'(acc_size);

  lsu_align_chk #(.OFS_W(OFS_W)) align_i (
    .size(sz), .ofs(addr_lo), .misalign(mis_c)
  );

  lsu_load_extract #(.DATA_W(DATA_W)) load_i (
    .word(rd_word), .ofs(addr_lo), .size(sz), .sign_ext(sign_ext),
    .big_end(big_end), .data(ld_c)
  );

  lsu_store_place #(.DATA_W(DATA_W)) store_i (
    .st_val(st_val), .ofs(addr_lo), .size(sz), .big_end(big_end),
    .misalign(mis_c), .st_word(st_c), .st_be(be_c)
  );

  lsu_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) out_i (
    .clk(clk), .rst(rst),
    .d({ld_c, mis_c, st_c, be_c}),
    .q({ld_data, misalign, st_word, st_be})
  );
endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int LANES  = DATA_W / 8,
  localparam int OFS_W  = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] rd_word,
  input logic [OFS_W-1:0]  addr_lo,
  input logic [1:0]        acc_size,
  input logic              sign_ext,
  input logic              big_end,
  input logic [DATA_W-1:0] st_val,
  input logic [DATA_W-1:0] ld_data,
  input logic              misalign,
  input logic [DATA_W-1:0] st_word,
  input logic [LANES-1:0]  st_be
);
  logic [DATA_W-1:0] wd_q, sv_q, wd_s, sv_s;
  logic [OFS_W-1:0]  ofs_q, ofs_s;
  logic [1:0]        sz_q, sz_s;
  logic              sgn_q, be_q, sgn_s, be_s, warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      warm <= 1'b0; wd_q <= '0; sv_q <= '0; ofs_q <= '0;
      sz_q <= '0; sgn_q <= 1'b0; be_q <= 1'b0;
    end else begin
      warm <= 1'b1; wd_q <= rd_word; sv_q <= st_val; ofs_q <= addr_lo;
      sz_q <= acc_size; sgn_q <= sign_ext; be_q <= big_end;
    end
  end

  assign wd_s  = REG_OUT ? wd_q  : rd_word;
  assign sv_s  = REG_OUT ? sv_q  : st_val;
  assign ofs_s = REG_OUT ? ofs_q : addr_lo;
  assign sz_s  = REG_OUT ? sz_q  : acc_size;
  assign sgn_s = REG_OUT ? sgn_q : sign_ext;
  assign be_s  = REG_OUT ? be_q  : big_end;

  // R2
  rsvd_size_misalign_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    (sz_s == 2'b11) |-> misalign);
  // R2
  word_offset_misalign_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    (sz_s == 2'b10 && ofs_s != '0) |-> misalign);
  // R2
  byte_never_misalign_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    (sz_s == 2'b00) |-> !misalign);
  // R6
  zero_fill_byte_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    (sz_s == 2'b00 && !sgn_s) |-> (ld_data[DATA_W-1:8] == '0));
  // R5
  sign_fill_half_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    (sz_s == 2'b01 && sgn_s && !misalign) |-> (ld_data[DATA_W-1:16] == {(DATA_W-16){ld_data[15]}}));
  // R7
  word_le_pass_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    (sz_s == 2'b10 && !be_s && !misalign) |-> (ld_data == wd_s));
  // R8
  word_le_store_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    (sz_s == 2'b10 && !be_s && !misalign) |-> (st_word == sv_s));
  // R9
  be_off_on_misalign_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    misalign |-> (st_be == '0));
  // R9
  byte_be_single_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    (sz_s == 2'b00) |-> ($countones(st_be) == 1));
  // R9
  word_be_full_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    (sz_s == 2'b10 && !misalign) |-> (st_be == '1));
endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rst(rst), .rd_word(rd_word), .addr_lo(addr_lo), .acc_size(acc_size),
  .sign_ext(sign_ext), .big_end(big_end), .st_val(st_val), .ld_data(ld_data),
  .misalign(misalign), .st_word(st_word), .st_be(st_be)
);

// File: tb/lsu_lane_unit_tb.sv
module lsu_lane_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] rd_word = '0, st_val = '0;
  logic [1:0]  addr_lo = '0, acc_size = '0;
  logic        sign_ext = 1'b0, big_end = 1'b0;
  logic [31:0] ld_data, st_word;
  logic        misalign;
  logic [3:0]  st_be;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  lsu_lane_unit dut_i (
    .clk(clk), .rst(rst), .rd_word(rd_word), .addr_lo(addr_lo), .acc_size(acc_size),
    .sign_ext(sign_ext), .big_end(big_end), .st_val(st_val), .ld_data(ld_data),
    .misalign(misalign), .st_word(st_word), .st_be(st_be)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h (sz=%0d ofs=%0d sgn=%0b big=%0b)",
               req, act, exp, acc_size, addr_lo, sign_ext, big_end);
    end
  endtask

  function automatic logic [31:0] pattern(input int p);
    case (p)
      0: return 32'h80FF7F01;
      1: return 32'h7F8001FE;
      2: return 32'hFFFFFFFF;
      3: return 32'h00000000;
      default: return (32'h9E3779B9 * (p + 1)) ^ (32'(p) << 28);
    endcase
  endfunction

  task automatic run_one(input logic [31:0] raw, input logic [31:0] sv,
                         input int sz, input int a, input bit sg, input bit bg);
    int n;
    bit mis;
    logic [31:0] exp_ld, exp_sw;
    logic [3:0]  exp_be;
    rd_word = raw; st_val = sv; acc_size = 2'(sz); addr_lo = 2'(a);
    sign_ext = sg; big_end = bg;
    @(posedge clk); @(negedge clk);
    n   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    mis = (sz == 3) || (a % n != 0);
    check("R2 misalign", {31'b0, misalign}, {31'b0, mis});
    if (mis) begin
      check("R9 be off", {28'b0, st_be}, 32'h0);
    end else begin
      exp_ld = '0;
      for (int i = 0; i < n; i++) begin
        if (bg) exp_ld = exp_ld | (32'(raw[8*(a+i) +: 8]) << (8*(n-1-i)));
        else    exp_ld = exp_ld | (32'(raw[8*(a+i) +: 8]) << (8*i));
      end
      if (n < 4 && sg && exp_ld[8*n-1]) exp_ld = exp_ld | (32'hFFFFFFFF << (8*n));
      if (sz == 0)      check("R1 byte lane", ld_data, exp_ld);
      else if (sz == 2) check("R7 word load", ld_data, exp_ld);
      else if (bg)      check("R4 BE half", ld_data, exp_ld);
      else              check("R3 LE half", ld_data, exp_ld);
      if (n < 4) begin
        if (sg) check("R5 sign ext", ld_data >> (8*n), (exp_ld[8*n-1] ? 32'hFFFFFFFF >> (8*n) : 32'h0));
        else    check("R6 zero fill", ld_data >> (8*n), 32'h0);
      end
      exp_sw = '0; exp_be = '0;
      for (int k = 0; k < 4; k++) begin
        int i;
        i = k % n;
        exp_sw[8*k +: 8] = bg ? sv[8*(n-1-i) +: 8] : sv[8*i +: 8];
        exp_be[k] = (k >= a) && (k < a + n);
      end
      check("R8 store lanes", st_word, exp_sw);
      check("R9 byte enables", {28'b0, st_be}, {28'b0, exp_be});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset ld", ld_data, 32'h0);
    check("R10 reset st", st_word, 32'h0);
    check("R10 reset flags", {27'b0, misalign, st_be}, 32'h0);
    rst = 1'b0;
    rd_word = 32'hCAFEF00D; acc_size = 2'b10; addr_lo = 2'b00;
    #1 check("R10 no early change", ld_data, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R10 one-edge latency", ld_data, 32'hCAFEF00D);
    for (int p = 0; p < 8; p++)
      for (int sz = 0; sz < 4; sz++)
        for (int a = 0; a < 4; a++)
          for (int s = 0; s < 4; s++)
            run_one(pattern(p), pattern(p + 9) ^ 32'hA5C35A3C, sz, a, s[0], s[1]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule